// File: doc/BRIEF.md
# CAN Time-Quantum Prescaler

This block turns a module system clock into the time-quantum tick that a CAN bit-timing unit counts. It has three dividers in a chain, all on the one input clock. The first is a power-of-two pre-divider, with ratios of 1, 2, 4, 8 or 16 chosen by a select code. The second is a baud-rate prescaler that divides by P+1, where P is a 4-bit value. The third halves the rate. The tick therefore arrives at fCAN/(ratio·2·(P+1)).

The output is a one-cycle clock-enable strobe in the input clock domain. No clock is gated or derived. The select code and P are captured only when the synchronous restart input is high. The same restart clears every counter, so a new setting starts with a clean phase. An undefined select code makes the block divide by 1 and raises a configuration-error flag.

Top module: `can_tq_prescaler`

## Requirements
- R1: While reset is held, and after it, `tq_en_o` and `cfg_err_o` are low. The captured setting is select 0 with P=0, which gives a period of 2 cycles. The first strobe appears on the third rising edge after `rst_ni` rises, because reset release passes through a two-stage synchronizer.
- R2: Select codes 0, 1, 2, 3 and 4 set the pre-divider ratio to 1, 2, 4, 8 and 16 (that is, 2 to the power of the code).
- R3: The prescaler divides by P+1 for every P from 0 to 15.
- R4: The final stage halves the rate, so the strobe period is exactly ratio·(P+1)·2 clock cycles.
- R5: Each strobe lasts one clock cycle. The strobe is never high in two consecutive cycles, and it is low in any cycle in which `restart_i` is high.
- R6: Take the rising edge that samples `restart_i` high as edge 0. The first strobe is visible after edge N-1, where N is the full period, and then again every N cycles.
- R7: Changes on `div_sel_i` and `brp_i` while `restart_i` is low do not change the strobe period or `cfg_err_o`.
- R8: Select codes 5, 6 and 7 divide by 1 and drive `cfg_err_o` high. A valid code captured at the next restart drives it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module system clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| restart_i | input | 1 | Synchronous restart; captures the setting and clears the counters |
| div_sel_i | input | 3 | Pre-divider select code (0..4 valid) |
| brp_i | input | 4 | Prescaler value P (divide by P+1) |
| tq_en_o | output | 1 | One-cycle time-quantum strobe |
| cfg_err_o | output | 1 | High while the captured select code is undefined |

## Verification
The bench sweeps all eight select codes against all sixteen P values and compares every cycle of two full periods with the expected pattern. Each expected value is computed from the period formula and the cycle's distance from the restart edge. The check of the first period separates a counter that is misaligned after restart from one whose wrap value is wrong. The spacing between the two strobes separates errors in the pre-divider ratio from errors in the P+1 and halving stages. In every sweep the select and P inputs are scrambled without a restart, so a design that tracks its inputs directly instead of the captured setting shows up as a changed period. The undefined codes check the divide-by-1 fallback together with the error flag. A reset-release check fixes the latency of the synchronizer.

// File: rtl/can_tq_pkg.sv
package can_tq_pkg;
  localparam int SEL_W       = 3;  // width of the pre-divider select code
  localparam int PRE_MAX_LOG = 4;  // largest pre-divider ratio is 2**PRE_MAX_LOG
  localparam int BRP_W       = 4;  // width of the prescaler value P

  // A select code is valid when it names a ratio from 1 up to 2**PRE_MAX_LOG.
  function automatic logic sel_valid(input logic [SEL_W-1:0] s);
    return s <= SEL_W'(PRE_MAX_LOG);
  endfunction

  // Wrap value of the pre-divider counter; an undefined code falls back to divide-by-1.
  function automatic logic [PRE_MAX_LOG-1:0] pre_limit(input logic [SEL_W-1:0] s);
    logic [PRE_MAX_LOG:0] one;
    logic [PRE_MAX_LOG:0] tmp;
    one = (PRE_MAX_LOG+1)'(1);
    if (!sel_valid(s)) begin
      tmp = '0;
    end else begin
      tmp = (one << s) - one;
    end
    return tmp[PRE_MAX_LOG-1:0];
  endfunction
endpackage

// File: rtl/can_tq_rst_sync.sv
module can_tq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  // Assertion is asynchronous; release moves through the flop chain.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/can_tq_div_stage.sv
module can_tq_div_stage #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == lim_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign en_o = en_i && !clr_i && wrap;

  // The limit changes only together with a clear, so the count never passes it.
  assert_cnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_i);
  // This stage can fire only on a cycle in which the stage before it fires.
  assert_chain_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> en_i);
  // A clear leaves the counter at zero on the next cycle.
  assert_clear_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/can_tq_prescaler.sv
module can_tq_prescaler
  import can_tq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tq_en_o,
  output logic             cfg_err_o
);
  localparam int HALF_W = 1;

  logic             rst_n_int;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [BRP_W-1:0] brp_q, brp_d;
  logic             pre_en, brp_en, half_en;

  can_tq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  // The setting is captured only on restart.
  always_comb begin
    sel_d = sel_q;
    brp_d = brp_q;
    if (restart_i) begin
      sel_d = div_sel_i;
      brp_d = brp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      sel_q <= '0;
      brp_q <= '0;
    end else begin
      sel_q <= sel_d;
      brp_q <= brp_d;
    end
  end

  // Stage 1: power-of-two pre-divider.
  can_tq_div_stage #(.CNT_W(PRE_MAX_LOG)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .clr_i  (restart_i),
    .en_i   (1'b1),
    .lim_i  (pre_limit(sel_q)),
    .en_o   (pre_en)
  );

  // Stage 2: divide by P+1.
  can_tq_div_stage #(.CNT_W(BRP_W)) u_brp (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .clr_i  (restart_i),
    .en_i   (pre_en),
    .lim_i  (brp_q),
    .en_o   (brp_en)
  );

  // Stage 3: fixed halving.
  can_tq_div_stage #(.CNT_W(HALF_W)) u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .clr_i  (restart_i),
    .en_i   (brp_en),
    .lim_i  (HALF_W'(1)),
    .en_o   (half_en)
  );

  assign tq_en_o   = half_en;
  assign cfg_err_o = !sel_valid(sel_q);

  assert_single_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    tq_en_o |=> !tq_en_o);
  assert_quiet_on_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    restart_i |-> !tq_en_o);
  assert_hold_setting_R7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !$past(restart_i) |-> ($stable(brp_q) && $stable(sel_q)));
  assert_err_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !$past(restart_i) |-> $stable(cfg_err_o));
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_n_int |-> (!tq_en_o && !cfg_err_o));
endmodule

// File: tb/can_tq_prescaler_tb.sv
module can_tq_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic [2:0] sel = '0;
  logic [3:0] brp = '0;
  logic       tq_en;
  logic       cfg_err;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_tq_prescaler u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .restart_i (restart),
    .div_sel_i (sel),
    .brp_i     (brp),
    .tq_en_o   (tq_en),
    .cfg_err_o (cfg_err)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One setting: restart, then two full periods compared cycle by cycle.
  task automatic run_cfg(input int s, input int p);
    int ratio, n, first, second, cnt;
    bit valid;
    valid = (s <= 4);
    ratio = valid ? (1 << s) : 1;
    n = ratio * (p + 1) * 2;
    first = -1; second = -1; cnt = 0;
    @(posedge clk); #1;
    sel = 3'(s); brp = 4'(p); restart = 1'b1;
    #1 check("R5", int'(tq_en), 0, "strobe during restart");
    @(posedge clk); #1;        // edge 0 captured the setting
    restart = 1'b0;
    check("R8", int'(cfg_err), valid ? 0 : 1, $sformatf("err flag sel=%0d", s));
    for (int j = 1; j <= 2 * n; j++) begin
      @(posedge clk); #1;
      if (j == 1) begin        // scramble inputs without restart
        sel = sel ^ 3'b101;
        brp = brp ^ 4'hA;
      end
      check((j < n) ? "R6" : "R4", int'(tq_en), ((j % n) == n - 1) ? 1 : 0,
            $sformatf("strobe sel=%0d P=%0d cycle=%0d", s, p, j));
      if (tq_en) begin
        cnt++;
        if (first < 0) first = j; else if (second < 0) second = j;
      end
    end
    check("R7", int'(cfg_err), valid ? 0 : 1, "err flag after scramble");
    check("R2", cnt, 2, $sformatf("strobe count sel=%0d P=%0d", s, p));
    check("R3", second - first, n, $sformatf("period sel=%0d P=%0d", s, p));
  endtask

  initial begin
    // R1: reset state and the first strobe after release (default period 2).
    #1;
    check("R1", int'(tq_en), 0, "strobe in reset");
    check("R1", int'(cfg_err), 0, "err in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int e = 1; e <= 4; e++) begin
      @(posedge clk); #1;
      check("R1", int'(tq_en), (e == 3) ? 1 : 0, $sformatf("strobe edge %0d after reset", e));
      check("R1", int'(cfg_err), 0, "err after reset");
    end
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 16; p++) begin
        run_cfg(s, p);
      end
    end
    // R8: an error clears once a valid code is captured.
    run_cfg(7, 3);
    run_cfg(2, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule